// File: doc/BRIEF.md
# Snapshot-Freezing BCD Real-Time Clock Register Bank

This block keeps calendar time in packed BCD: century, year, month, date, day of week, hours, minutes and seconds, in 24-hour form. A one-second strobe, `tick_1hz`, advances a hidden set of counters. Every carry from seconds up to the century completes in the cycle of the strobe. Software reaches a second set of registers, the visible copy, through a small parallel port. The port has active-low chip-enable, output-enable and write-enable strobes and separate write and read data buses. A driver-enable output stands in for the high-impedance state of a shared bus.

The block keeps a coherent snapshot for software. Setting the freeze flag (bit 6 of the control/century register) holds the whole visible copy, while the hidden counters keep counting. Clearing the flag arms a release. On the next second strobe every visible register is reloaded at once from the counters. A three-state machine governs this:
- `ST_LIVE`: the visible copy follows the counters.
- `ST_FROZEN`: the visible copy is held.
- `ST_RELEASE`: the flag is clear, but the snapshot stays until the next strobe.

Transitions:
- LIVE→FROZEN on a control write with the flag set.
- FROZEN→RELEASE on a control write with the flag clear.
- RELEASE→FROZEN on a control write with the flag set.
- RELEASE→LIVE on a second strobe that does not coincide with a write.

Top module: `rtc_snapshot_bank`

## Requirements
- R1: After reset the time reads 00:00:00, the date reads 01, the month 01, the day of week 1, the year 00 and the century 00, and the freeze flag reads 0.
- R2: Each second strobe advances the packed-BCD seconds. Seconds and minutes wrap from 59 to 00 and carry upward. Hours wrap from 23 to 00 and carry into the date.
- R3: The date wraps to 01 after day 30 for months 04, 06, 09 and 11, after day 31 for the other months, and after day 29 for February when the two-digit year is divisible by 4 (28 otherwise). Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century, which wraps from 39 to 00.
- R4: The day of week advances with every date carry and cycles 1 through 7.
- R5: Address map (addr): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control/century. When ce_n=0, we_n=1 and oe_n=0, rd_en is 1 and rdata carries the visible register at addr. In every other case rd_en is 0 and rdata is 0.
- R6: A clock edge with ce_n=0 and we_n=0 writes wdata to the register at addr. In the live state the write goes to both the counter and the visible copy, so it reads back on the next cycle. A second strobe in the same cycle as a write is dropped.
- R7: Writing the control register with bit 6 set enters the frozen state. While frozen, every visible register keeps its value across any number of strobes.
- R8: While frozen, the hidden counters keep advancing on every strobe.
- R9: After the flag is written 0, the visible registers still show the snapshot until the next strobe. On that strobe all of them are reloaded together with the current counter values.
- R10: A time write made while frozen or while a release is pending loads only the counter. The visible copy shows the new value only after the reload.
- R11: Reading address 7 returns bit 7 as 0, bit 6 as the freeze flag (1 only in the frozen state), and bits 5:0 as the visible century in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driving |
| rd_en | output | 1 | Read-bus driver enable (0 = high impedance) |

## Verification
A stuck or mis-sequenced freeze state shows at the port on the first read after a strobe. The visible registers either move while they should be held, or keep the old snapshot after the strobe that should reload them. A wrong carry in the counters stays hidden during a freeze and appears in full on the read after the release. For that reason the release check compares every register against a reference model advanced by the whole elapsed tick count. Month-length and leap-year faults appear only on the strobe that ends a month, so those strobes are driven directly.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int BCD_W  = 8;
    localparam int REG_AW = 3;

    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam logic [2:0] A_SEC  = 3'd0;
    localparam logic [2:0] A_MIN  = 3'd1;
    localparam logic [2:0] A_HR   = 3'd2;
    localparam logic [2:0] A_DOW  = 3'd3;
    localparam logic [2:0] A_DATE = 3'd4;
    localparam logic [2:0] A_MON  = 3'd5;
    localparam logic [2:0] A_YR   = 3'd6;
    localparam logic [2:0] A_CTL  = 3'd7;

    localparam int FREEZE_BIT = 6;

    localparam rtc_time_t RESET_TIME = '{cen: 8'h00, yr: 8'h00, mon: 8'h01,
                                         date: 8'h01, dow: 8'h01, hr: 8'h00,
                                         min: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // 10 = 2 (mod 4), so the year modulo 4 is (2*tens_lsb + ones) mod 4
    function automatic logic [7:0] month_days(input logic [7:0] mon,
                                              input logic       yr_tens_lsb,
                                              input logic [3:0] yr_ones);
        logic [4:0] m4;
        m4 = {3'b000, yr_tens_lsb, 1'b0} + {1'b0, yr_ones};
        if (mon == 8'h02)
            return (m4[1:0] == 2'b00) ? 8'h29 : 8'h28;
        else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11)
            return 8'h30;
        else
            return 8'h31;
    endfunction

    function automatic rtc_time_t set_field(input rtc_time_t t,
                                            input logic [2:0] a,
                                            input logic [7:0] d);
        rtc_time_t r;
        r = t;
        case (a)
            A_SEC:   r.sec  = d;
            A_MIN:   r.min  = d;
            A_HR:    r.hr   = d;
            A_DOW:   r.dow  = d;
            A_DATE:  r.date = d;
            A_MON:   r.mon  = d;
            A_YR:    r.yr   = d;
            default: r.cen  = {2'b00, d[5:0]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import rtc_snap_pkg::*;
#(
    parameter logic [7:0] CENT_LAST = 8'h39
) (
    input  rtc_time_t cur,
    output rtc_time_t nxt
);

    logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;
    logic [7:0] dim;

    always_comb begin
        dim   = month_days(cur.mon, cur.yr[4], cur.yr[3:0]);
        nxt   = cur;
        c_min = (cur.sec == 8'h59);
        nxt.sec = c_min ? 8'h00 : bcd_inc(cur.sec);

        c_hr = c_min && (cur.min == 8'h59);
        if (c_min)
            nxt.min = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);

        c_day = c_hr && (cur.hr == 8'h23);
        if (c_hr)
            nxt.hr = (cur.hr == 8'h23) ? 8'h00 : bcd_inc(cur.hr);

        c_mon = c_day && (cur.date == dim);
        if (c_day) begin
            nxt.date = (cur.date == dim) ? 8'h01 : bcd_inc(cur.date);
            nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
        end

        c_yr = c_mon && (cur.mon == 8'h12);
        if (c_mon)
            nxt.mon = (cur.mon == 8'h12) ? 8'h01 : bcd_inc(cur.mon);

        c_cen = c_yr && (cur.yr == 8'h99);
        if (c_yr)
            nxt.yr = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);

        if (c_cen)
            nxt.cen = (cur.cen == CENT_LAST) ? 8'h00 : bcd_inc(cur.cen);
    end

endmodule

// File: rtl/rtc_freeze_fsm.sv
module rtc_freeze_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_go,
    input  logic ctl_wr,
    input  logic ctl_freeze,
    output logic vis_live,
    output logic vis_reload,
    output logic read_flag
);

    typedef enum logic [1:0] {
        ST_LIVE    = 2'd0,
        ST_FROZEN  = 2'd1,
        ST_RELEASE = 2'd2
    } frz_state_e;

    frz_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LIVE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LIVE:    if (ctl_wr && ctl_freeze)  st_d = ST_FROZEN;
            ST_FROZEN:  if (ctl_wr && !ctl_freeze) st_d = ST_RELEASE;
            ST_RELEASE: if (ctl_wr && ctl_freeze)  st_d = ST_FROZEN;
                        else if (tick_go)          st_d = ST_LIVE;
            default:    st_d = ST_LIVE;
        endcase
    end

    always_comb begin
        vis_live   = 1'b0;
        vis_reload = 1'b0;
        read_flag  = 1'b0;
        unique case (st_q)
            ST_LIVE: begin
                vis_live   = 1'b1;
                vis_reload = tick_go;
            end
            ST_FROZEN:  read_flag  = 1'b1;
            ST_RELEASE: vis_reload = tick_go;
            default: ;
        endcase
    end

    AST_FREEZE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_freeze) |=> read_flag) else $error("freeze entry"); // R7

endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
    import rtc_snap_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = BCD_W
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  rtc_time_t     vis,
    input  logic          read_flag,
    output logic          wr_en,
    output logic          rd_en,
    output logic [DW-1:0] rdata
);

    logic [7:0] fld;

    always_comb begin
        wr_en = !ce_n && !we_n;
        rd_en = !ce_n && we_n && !oe_n;
        case (addr)
            A_SEC:   fld = vis.sec;
            A_MIN:   fld = vis.min;
            A_HR:    fld = vis.hr;
            A_DOW:   fld = vis.dow;
            A_DATE:  fld = vis.date;
            A_MON:   fld = vis.mon;
            A_YR:    fld = vis.yr;
            default: fld = {vis.cen[7], vis.cen[6] | read_flag, vis.cen[5:0]};
        endcase
        rdata = rd_en ? fld : '0;
    end

    always_comb begin
        AST_BUS_IDLE: assert (!(ce_n && rd_en)) else $error("bus idle"); // R5
    end

endmodule

// File: rtl/rtc_snapshot_bank.sv
module rtc_snapshot_bank
    import rtc_snap_pkg::*;
#(
    parameter int         ADDR_W    = REG_AW,
    parameter int         DATA_W    = BCD_W,
    parameter logic [7:0] CENT_LAST = 8'h39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_en
);

    rtc_time_t cnt_q, vis_q, cnt_nxt;
    logic wr_en, tick_go, ctl_wr;
    logic vis_live, vis_reload, read_flag;

    assign tick_go = tick_1hz && !wr_en;
    assign ctl_wr  = wr_en && (addr == A_CTL);

    rtc_calendar_next #(.CENT_LAST(CENT_LAST)) u_next (
        .cur (cnt_q),
        .nxt (cnt_nxt)
    );

    rtc_freeze_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_go    (tick_go),
        .ctl_wr     (ctl_wr),
        .ctl_freeze (wdata[FREEZE_BIT]),
        .vis_live   (vis_live),
        .vis_reload (vis_reload),
        .read_flag  (read_flag)
    );

    rtc_bus_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .vis       (vis_q),
        .read_flag (read_flag),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rdata     (rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RESET_TIME;
            vis_q <= RESET_TIME;
        end else begin
            if (wr_en)
                cnt_q <= set_field(cnt_q, addr, wdata);
            else if (tick_1hz)
                cnt_q <= cnt_nxt;

            if (wr_en && vis_live)
                vis_q <= set_field(vis_q, addr, wdata);
            else if (vis_reload)
                vis_q <= cnt_nxt;
        end
    end

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(read_flag) |-> $stable(vis_q)) else $error("snapshot moved"); // R7
    AST_CNT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (read_flag && tick_go) |=> (cnt_q != $past(cnt_q))) else $error("counter stalled"); // R8
    AST_RELOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        vis_reload |=> (vis_q == cnt_q)) else $error("reload mismatch"); // R9
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_go && cnt_q.sec == 8'h59) |=> (cnt_q.sec == 8'h00)) else $error("sec wrap"); // R2
    AST_LIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vis_live) |=> (vis_q == cnt_q)) else $error("live write"); // R6

endmodule

// File: tb/rtc_snapshot_bank_bench.sv
module rtc_snapshot_bank_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rd_en;

    int n_chk = 0, n_fail = 0;
    int r [8];      // reference: 0 sec,1 min,2 hr,3 dow,4 date,5 mon,6 yr,7 cen
    int snap [8];
    bit frz = 1'b0;

    always #10 clk = ~clk;

    rtc_snapshot_bank u_rtc_snapshot_bank (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rd_en(rd_en)
    );

    function automatic logic [7:0] to_bcd(input int x);
        return 8'(((x / 10) << 4) | (x % 10));
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_adv();
        int dim;
        r[0]++;
        if (r[0] == 60) begin r[0] = 0; r[1]++; end
        if (r[1] == 60) begin r[1] = 0; r[2]++; end
        if (r[2] == 24) begin
            r[2] = 0; r[4]++;
            r[3] = (r[3] == 7) ? 1 : r[3] + 1;
            if (r[5] == 2) dim = (r[6] % 4 == 0) ? 29 : 28;
            else if (r[5] == 4 || r[5] == 6 || r[5] == 9 || r[5] == 11) dim = 30;
            else dim = 31;
            if (r[4] > dim) begin r[4] = 1; r[5]++; end
            if (r[5] == 13) begin r[5] = 1; r[6]++; end
            if (r[6] == 100) begin r[6] = 0; r[7]++; end
            if (r[7] == 40) r[7] = 0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
        #2;
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
            ref_adv();
        end
    endtask

    task automatic check_vals(input int v [8], input bit f, input string tag);
        logic [7:0] x;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), x);
            chk($sformatf("%s addr%0d", tag, a), x, to_bcd(v[a]));
        end
        rd(3'd7, x);
        chk($sformatf("%s R11 ctl", tag), x, {1'b0, f, to_bcd(v[7])[5:0]});
    endtask

    task automatic set_all(input int c, input int y, input int mo, input int d,
                           input int w, input int h, input int mi, input int s);
        r[7] = c; r[6] = y; r[5] = mo; r[4] = d; r[3] = w; r[2] = h; r[1] = mi; r[0] = s;
        for (int a = 0; a < 7; a++) wr(3'(a), to_bcd(r[a]));
        wr(3'd7, to_bcd(r[7]));
    endtask

    task automatic t_reset();
        r = '{0, 0, 0, 1, 1, 1, 0, 0};
        check_vals(r, 1'b0, "R1 reset");
    endtask

    task automatic t_bus();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; #2;
        chk("R5 deselect en", {7'd0, rd_en}, 8'h00);
        chk("R5 deselect data", rdata, 8'h00);
        ce_n = 1'b0; oe_n = 1'b1; #2;
        chk("R5 oe off en", {7'd0, rd_en}, 8'h00);
        oe_n = 1'b0; addr = 3'd4; #2;
        chk("R5 read en", {7'd0, rd_en}, 8'h01);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_basic();
        logic [7:0] x;
        set_all(20, 5, 3, 14, 6, 23, 59, 58);
        check_vals(r, 1'b0, "R6 write readback");
        tick(3);
        check_vals(r, 1'b0, "R2 R4 hour rollover");
        // write and strobe in the same cycle: strobe dropped
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 3'd0; wdata = 8'h42; tick_1hz = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; tick_1hz = 1'b0;
        r[0] = 42;
        rd(3'd0, x); chk("R6 write beats tick sec", x, 8'h42);
        rd(3'd1, x); chk("R6 write beats tick min", x, to_bcd(r[1]));
    endtask

    task automatic t_calendar();
        set_all(20, 24, 2, 28, 3, 23, 59, 59);
        tick(1); check_vals(r, 1'b0, "R3 leap feb28");
        set_all(20, 24, 2, 29, 7, 23, 59, 59);
        tick(1); check_vals(r, 1'b0, "R3 R4 leap feb29 end");
        set_all(20, 23, 2, 28, 2, 23, 59, 59);
        tick(1); check_vals(r, 1'b0, "R3 plain feb end");
        set_all(20, 23, 4, 30, 5, 23, 59, 59);
        tick(1); check_vals(r, 1'b0, "R3 april end");
        set_all(20, 99, 12, 31, 4, 23, 59, 59);
        tick(1); check_vals(r, 1'b0, "R3 century carry");
        set_all(39, 99, 12, 31, 4, 23, 59, 59);
        tick(1); check_vals(r, 1'b0, "R3 century wrap");
    endtask

    task automatic t_freeze();
        set_all(21, 24, 2, 29, 1, 23, 58, 30);
        snap = r;
        wr(3'd7, 8'h40 | to_bcd(r[7]));
        frz = 1'b1;
        check_vals(snap, 1'b1, "R7 frozen entry");
        tick(100);
        check_vals(snap, 1'b1, "R7 R8 snapshot held");
        wr(3'd7, to_bcd(r[7]));
        frz = 1'b0;
        check_vals(snap, 1'b0, "R9 pending release");
        tick(1);
        check_vals(r, 1'b0, "R8 R9 reload after release");
    endtask

    task automatic t_frozen_write();
        logic [7:0] x;
        snap = r;
        wr(3'd7, 8'h40 | to_bcd(r[7]));
        wr(3'd1, 8'h30);
        r[1] = 30;
        rd(3'd1, x); chk("R10 frozen write hidden", x, to_bcd(snap[1]));
        wr(3'd7, to_bcd(r[7]));
        wr(3'd2, 8'h11);
        r[2] = 11;
        rd(3'd2, x); chk("R10 release write hidden", x, to_bcd(snap[2]));
        tick(1);
        check_vals(r, 1'b0, "R10 reload shows writes");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bus();
        t_basic();
        t_calendar();
        t_freeze();
        t_frozen_write();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule